// File: doc/BRIEF.md
# Nearest-Rate Configuration Selector

This block keeps a fixed table of supported output frequencies. Each frequency comes with the divider and band settings that produce it. A clock controller uses it in two ways. A round request returns the frequency in the table that lies closest to a requested value. A set request returns the settings of an entry whose frequency equals the request exactly. If no entry matches exactly, the set request reports an error.

The table is fixed at elaboration through a parameter. The table ends early at the first entry whose frequency is zero, and otherwise at the last entry the depth parameter allows. A request is accepted on `start_i` while the block is idle. The block then walks the table one entry per clock. It ends the walk with a single-cycle `done_o` pulse. The result stays on the outputs until the next accepted request finishes. Applying the chosen settings is left to the caller.

Top module: `rate_pick`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `err_o` are 0, and `rate_o` and all setting outputs are 0.
- R2: A round request (`mode_i` = 0) returns in `rate_o` the table frequency with the smallest absolute distance to `req_rate_i`, together with that entry's idiv, fbdiv, odiv and band values. `err_o` is 0.
- R3: When two entries are equally distant from the request, the round result is the entry that comes earlier in the table.
- R4: The walk covers entries from index 0 up to, but not including, the first entry with frequency zero. It stops after index DEPTH-1 when no such entry exists.
- R5: A round request on a table whose entry 0 has frequency zero ends with `err_o` = 1 and `err_code_o` = 0 (empty table).
- R6: A set request (`mode_i` = 1) whose `req_rate_i` equals an entry's frequency returns that entry's frequency and settings, with `err_o` = 0.
- R7: A set request with no exact match ends with `err_o` = 1 and `err_code_o` = 1 (no match). `rate_o` and all setting outputs are then 0.
- R8: A set request that hits entry j raises `done_o` on the (j+2)-th rising edge. The edge that samples `start_i` counts as the first.
- R9: `done_o` is high for exactly one cycle. The results stay unchanged while the block is idle and no new request starts.
- R10: A `start_i` that arrives while `busy_o` is 1 is ignored, together with the `mode_i` and `req_rate_i` values that come with it.
- R11: `busy_o` rises the cycle after an accepted start and stays high until the cycle in which `done_o` is high, where it is 0. A new start in that done cycle is accepted.
- R12: With TBL_SEL = 1, the table holds 297, 540 and 594 MHz. The 297 MHz entry carries idiv 0, fbdiv 21, odiv 2 and band 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, taken only while idle |
| mode_i | input | 1 | 0 = round to nearest, 1 = exact set |
| req_rate_i | input | 32 | Requested frequency in Hz |
| busy_o | output | 1 | Table walk in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Request failed |
| err_code_o | output | 1 | 0 = empty table, 1 = no exact match |
| rate_o | output | 32 | Chosen frequency in Hz |
| idiv_o | output | 5 | Input divider setting |
| fbdiv_o | output | 7 | Feedback divider setting |
| odiv_o | output | 2 | Output divider setting |
| band_o | output | 4 | Band setting |

## Verification
Two events can land in the same cycle: the completion of one walk and the start of the next. A start can also arrive in the middle of a walk. The bench issues every new request at the very edge where `done_o` of the previous one is still high, so each result of the sweeps also shows that the back-to-back start was taken. A second start with a different mode and request is also injected one cycle into a round walk. The bench judges it by requiring that the result belongs to the first request, with the tie rule applied.

// File: rtl/rate_pick_pkg.sv
package rate_pick_pkg;

  localparam int RATE_W  = 32;
  localparam int IDIV_W  = 5;
  localparam int FBDIV_W = 7;
  localparam int ODIV_W  = 2;
  localparam int BAND_W  = 4;

  typedef enum logic {MODE_ROUND = 1'b0, MODE_SET = 1'b1} mode_e;
  typedef enum logic {ERR_EMPTY = 1'b0, ERR_NO_MATCH = 1'b1} err_e;

  typedef struct packed {
    logic [RATE_W-1:0]  rate;
    logic [IDIV_W-1:0]  idiv;
    logic [FBDIV_W-1:0] fbdiv;
    logic [ODIV_W-1:0]  odiv;
    logic [BAND_W-1:0]  band;
  } cfg_t;

  function automatic cfg_t mk(int mhz, int iv, int fv, int ov);
    cfg_t c;
    c.rate  = RATE_W'(mhz * 1000000);
    c.idiv  = IDIV_W'(iv);
    c.fbdiv = FBDIV_W'(fv);
    c.odiv  = ODIV_W'(ov);
    c.band  = '0;
    return c;
  endfunction

  // sel 0: general table, sel 1: video table, other: empty
  function automatic cfg_t tbl_entry(int sel, int idx);
    cfg_t c;
    c = '0;
    if (sel == 0) begin
      case (idx)
        0:  c = mk(100, 0, 11, 3);
        1:  c = mk(133, 0, 15, 3);
        2:  c = mk(200, 1, 47, 3);
        3:  c = mk(233, 1, 27, 2);
        4:  c = mk(300, 1, 35, 2);
        5:  c = mk(333, 1, 39, 2);
        6:  c = mk(400, 1, 47, 2);
        7:  c = mk(500, 0, 14, 1);
        8:  c = mk(600, 0, 17, 1);
        9:  c = mk(700, 0, 20, 1);
        10: c = mk(800, 0, 23, 1);
        11: c = mk(900, 1, 26, 0);
        12: c = mk(1000, 1, 29, 0);
        13: c = mk(1100, 1, 32, 0);
        14: c = mk(1200, 1, 35, 0);
        15: c = mk(1300, 1, 38, 0);
        16: c = mk(1400, 1, 41, 0);
        17: c = mk(1500, 1, 44, 0);
        18: c = mk(1600, 1, 47, 0);
        default: c = '0;
      endcase
    end else if (sel == 1) begin
      case (idx)
        0: c = mk(297, 0, 21, 2);
        1: c = mk(540, 0, 19, 1);
        2: c = mk(594, 0, 21, 1);
        default: c = '0;
      endcase
    end
    return c;
  endfunction

endpackage

// File: rtl/rate_pick_rom.sv
module rate_pick_rom
  import rate_pick_pkg::*;
#(
  parameter int TBL_SEL = 0,
  parameter int DEPTH   = 20,
  localparam int IW     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [IW-1:0] idx_i,
  output cfg_t          ent_o
);

  cfg_t tbl [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    assign tbl[g] = tbl_entry(TBL_SEL, g);
  end

  always_comb begin
    ent_o = '0;
    if (int'(idx_i) < DEPTH) ent_o = tbl[idx_i];
  end

endmodule

// File: rtl/rate_pick_dist.sv
module rate_pick_dist #(
  parameter int W = 32
) (
  input  logic [W-1:0] req_i,
  input  logic [W-1:0] cand_i,
  input  logic [W-1:0] best_i,
  output logic         closer_o,
  output logic         exact_o
);

  logic [W-1:0] d_cand, d_best;

  assign d_cand   = (cand_i > req_i) ? cand_i - req_i : req_i - cand_i;
  assign d_best   = (best_i > req_i) ? best_i - req_i : req_i - best_i;
  // strict compare keeps the earlier entry on a tie
  assign closer_o = d_cand < d_best;
  assign exact_o  = cand_i == req_i;

endmodule

// File: rtl/rate_pick_ctrl.sv
module rate_pick_ctrl
  import rate_pick_pkg::*;
#(
  parameter int DEPTH = 20,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              mode_i,
  input  logic [RATE_W-1:0] req_i,
  input  cfg_t              ent_i,
  input  logic              closer_i,
  input  logic              exact_i,
  output logic [IW-1:0]     idx_o,
  output logic [RATE_W-1:0] req_q_o,
  output logic [RATE_W-1:0] best_rate_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              err_code_o,
  output cfg_t              res_o
);

  typedef enum logic {ST_IDLE, ST_SCAN} st_e;

  localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

  st_e           state_q;
  logic [IW-1:0] idx_q;
  mode_e         mode_q;
  logic [RATE_W-1:0] req_q;
  cfg_t          best_q, nxt_best, fin_ent, res_q;
  logic          fin, fin_err, fin_code, adv, last, ent_zero;
  logic          done_q, err_q, code_q;

  assign last     = idx_q == LAST;
  assign ent_zero = ent_i.rate == '0;

  always_comb begin
    fin      = 1'b0;
    fin_err  = 1'b0;
    fin_code = ERR_EMPTY;
    fin_ent  = '0;
    nxt_best = best_q;
    adv      = 1'b0;
    if (state_q == ST_SCAN) begin
      if (mode_q == MODE_SET) begin
        if (!ent_zero && exact_i) begin
          fin     = 1'b1;
          fin_ent = ent_i;
        end else if (ent_zero || last) begin
          fin      = 1'b1;
          fin_err  = 1'b1;
          fin_code = ERR_NO_MATCH;
        end else begin
          adv = 1'b1;
        end
      end else if (idx_q == '0) begin
        if (ent_zero) begin
          fin      = 1'b1;
          fin_err  = 1'b1;
          fin_code = ERR_EMPTY;
        end else begin
          nxt_best = ent_i;
          if (last) begin
            fin     = 1'b1;
            fin_ent = ent_i;
          end else begin
            adv = 1'b1;
          end
        end
      end else if (ent_zero) begin
        fin     = 1'b1;
        fin_ent = best_q;
      end else begin
        nxt_best = closer_i ? ent_i : best_q;
        if (last) begin
          fin     = 1'b1;
          fin_ent = nxt_best;
        end else begin
          adv = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      mode_q  <= MODE_ROUND;
      req_q   <= '0;
      best_q  <= '0;
      res_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      code_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_SCAN;
            idx_q   <= '0;
            mode_q  <= mode_e'(mode_i);
            req_q   <= req_i;
          end
        end
        default: begin
          if (fin) begin
            state_q <= ST_IDLE;
            res_q   <= fin_ent;
            err_q   <= fin_err;
            code_q  <= fin_code;
            done_q  <= 1'b1;
          end else if (adv) begin
            idx_q  <= idx_q + 1'b1;
            best_q <= nxt_best;
          end
        end
      endcase
    end
  end

  assign idx_o       = idx_q;
  assign req_q_o     = req_q;
  assign best_rate_o = best_q.rate;
  assign busy_o      = state_q == ST_SCAN;
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign err_code_o  = code_q;
  assign res_o       = res_q;

endmodule

// File: rtl/rate_pick.sv
module rate_pick
  import rate_pick_pkg::*;
#(
  parameter int TBL_SEL = 0,
  parameter int DEPTH   = 20
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               mode_i,
  input  logic [RATE_W-1:0]  req_rate_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               err_o,
  output logic               err_code_o,
  output logic [RATE_W-1:0]  rate_o,
  output logic [IDIV_W-1:0]  idiv_o,
  output logic [FBDIV_W-1:0] fbdiv_o,
  output logic [ODIV_W-1:0]  odiv_o,
  output logic [BAND_W-1:0]  band_o
);

  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [IW-1:0]     idx;
  cfg_t              ent, res;
  logic [RATE_W-1:0] req_q, best_rate;
  logic              closer, exact;

  rate_pick_rom #(.TBL_SEL(TBL_SEL), .DEPTH(DEPTH)) u_rom (
    .idx_i (idx),
    .ent_o (ent)
  );

  rate_pick_dist #(.W(RATE_W)) u_dist (
    .req_i    (req_q),
    .cand_i   (ent.rate),
    .best_i   (best_rate),
    .closer_o (closer),
    .exact_o  (exact)
  );

  rate_pick_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .mode_i      (mode_i),
    .req_i       (req_rate_i),
    .ent_i       (ent),
    .closer_i    (closer),
    .exact_i     (exact),
    .idx_o       (idx),
    .req_q_o     (req_q),
    .best_rate_o (best_rate),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (err_o),
    .err_code_o  (err_code_o),
    .res_o       (res)
  );

  assign rate_o  = res.rate;
  assign idiv_o  = res.idiv;
  assign fbdiv_o = res.fbdiv;
  assign odiv_o  = res.odiv;
  assign band_o  = res.band;

endmodule

// File: rtl/rate_pick_chk.sv
module rate_pick_chk
  import rate_pick_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic               mode_i,
  input logic [RATE_W-1:0]  req_rate_i,
  input logic               busy_o,
  input logic               done_o,
  input logic               err_o,
  input logic               err_code_o,
  input logic [RATE_W-1:0]  rate_o,
  input logic [IDIV_W-1:0]  idiv_o,
  input logic [FBDIV_W-1:0] fbdiv_o,
  input logic [ODIV_W-1:0]  odiv_o,
  input logic [BAND_W-1:0]  band_o
);

  logic              m_set;
  logic [RATE_W-1:0] m_req;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_set <= 1'b0;
      m_req <= '0;
    end else if (start_i && !busy_o) begin
      m_set <= mode_i;
      m_req <= req_rate_i;
    end
  end

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=>
      $stable({rate_o, idiv_o, fbdiv_o, odiv_o, band_o, err_o, err_code_o}));

  p_accept_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  p_done_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  p_err_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> (rate_o == '0 && idiv_o == '0 && fbdiv_o == '0));

  p_set_hit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_o && m_set) |-> (rate_o == m_req));

  p_round_err_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o && !m_set) |-> (err_code_o == ERR_EMPTY));

  p_round_nonzero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_o && !m_set) |-> (rate_o != '0));

endmodule

bind rate_pick rate_pick_chk u_chk (.*);

// File: tb/sim_rate_pick.sv
`timescale 1ns/1ps
module sim_rate_pick;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  st = '0;
  logic        mode = 1'b0;
  logic [31:0] req = '0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  logic        bz [3];
  logic        dn [3];
  logic        er [3];
  logic        ec [3];
  logic [31:0] rt [3];
  logic [4:0]  iv [3];
  logic [6:0]  fv [3];
  logic [1:0]  ov [3];
  logic [3:0]  bd [3];

  rate_pick #(.TBL_SEL(0), .DEPTH(20)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(st[0]), .mode_i(mode), .req_rate_i(req),
    .busy_o(bz[0]), .done_o(dn[0]), .err_o(er[0]), .err_code_o(ec[0]), .rate_o(rt[0]),
    .idiv_o(iv[0]), .fbdiv_o(fv[0]), .odiv_o(ov[0]), .band_o(bd[0]));
  rate_pick #(.TBL_SEL(1), .DEPTH(3)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(st[1]), .mode_i(mode), .req_rate_i(req),
    .busy_o(bz[1]), .done_o(dn[1]), .err_o(er[1]), .err_code_o(ec[1]), .rate_o(rt[1]),
    .idiv_o(iv[1]), .fbdiv_o(fv[1]), .odiv_o(ov[1]), .band_o(bd[1]));
  rate_pick #(.TBL_SEL(2), .DEPTH(4)) u2 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(st[2]), .mode_i(mode), .req_rate_i(req),
    .busy_o(bz[2]), .done_o(dn[2]), .err_o(er[2]), .err_code_o(ec[2]), .rate_o(rt[2]),
    .idiv_o(iv[2]), .fbdiv_o(fv[2]), .odiv_o(ov[2]), .band_o(bd[2]));

  localparam int N = 19;
  int unsigned mhz [N] = '{100,133,200,233,300,333,400,500,600,700,800,
                            900,1000,1100,1200,1300,1400,1500,1600};
  int unsigned idv [N] = '{0,0,1,1,1,1,1,0,0,0,0,1,1,1,1,1,1,1,1};
  int unsigned fbv [N] = '{11,15,47,27,35,39,47,14,17,20,23,26,29,32,35,38,41,44,47};
  int unsigned odv [N] = '{3,3,3,2,2,2,2,1,1,1,1,0,0,0,0,0,0,0,0};

  logic [31:0] c_rate;
  logic [4:0]  c_iv;
  logic [6:0]  c_fv;
  logic [1:0]  c_ov;
  logic [3:0]  c_bd;
  logic        c_er, c_ec;
  int          c_cyc;

  function automatic logic [31:0] hz(int unsigned m);
    return 32'(m) * 32'd1000000;
  endfunction

  function automatic logic [31:0] absd(logic [31:0] a, logic [31:0] b);
    return (a > b) ? a - b : b - a;
  endfunction

  function automatic int nearest(logic [31:0] r);
    int b = 0;
    for (int i = 1; i < N; i++)
      if (absd(r, hz(mhz[i])) < absd(r, hz(mhz[b]))) b = i;
    return b;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // caller is at a negedge; start driven there, result captured at done
  task automatic run(input int w, input logic m, input logic [31:0] q);
    mode = m;
    req = q;
    st[w] = 1'b1;
    @(negedge clk);
    st[w] = 1'b0;
    c_cyc = 1;
    while (!dn[w] && c_cyc < 100) begin
      @(negedge clk);
      c_cyc++;
    end
    if (!dn[w]) chk(1'b0, "R11 done timeout", 32'(c_cyc), 32'd0);
    c_rate = rt[w]; c_iv = iv[w]; c_fv = fv[w]; c_ov = ov[w]; c_bd = bd[w];
    c_er = er[w]; c_ec = ec[w];
  endtask

  task automatic chk_entry(input string tag, input int k);
    chk(c_er == 1'b0, {tag, " err"}, 32'(c_er), 0);
    chk(c_rate == hz(mhz[k]), {tag, " rate"}, c_rate, hz(mhz[k]));
    chk(c_iv == 5'(idv[k]) && c_fv == 7'(fbv[k]) && c_ov == 2'(odv[k]) && c_bd == 4'd0,
        {tag, " fields"}, {c_iv, c_fv, c_ov, c_bd}, 32'(k));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int w = 0; w < 3; w++) begin
      chk(!bz[w] && !dn[w] && !er[w], "R1 flags", {bz[w], dn[w], er[w]}, 0);
      chk(rt[w] == 0 && iv[w] == 0 && fv[w] == 0, "R1 outputs", rt[w], 0);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R2/R3 every entry exact, every midpoint and its neighbours
    for (int i = 0; i < N; i++) begin
      run(0, 1'b0, hz(mhz[i]));
      chk_entry("R2 exact", i);
    end
    for (int i = 0; i + 1 < N; i++) begin
      logic [31:0] mid = (hz(mhz[i]) + hz(mhz[i+1])) / 2;
      for (int d = -1; d <= 1; d++) begin
        run(0, 1'b0, mid + 32'(d));
        chk_entry("R3 midpoint", nearest(mid + 32'(d)));
      end
    end
    run(0, 1'b0, 32'd450000000);
    chk_entry("R3 tie keeps earlier", 6);
    run(0, 1'b0, 32'd0);
    chk_entry("R2 below table", 0);
    run(0, 1'b0, 32'hFFFF_FFFF);
    chk_entry("R2 above table", 18);
    for (int n = 0; n < 300; n++) begin
      logic [31:0] r = 32'($urandom_range(1800000000, 0));
      run(0, 1'b0, r);
      chk_entry("R2 random", nearest(r));
    end

    // R6/R8 set hits with latency
    for (int i = 0; i < N; i++) begin
      run(0, 1'b1, hz(mhz[i]));
      chk_entry("R6 set hit", i);
      chk(c_cyc == i + 2, "R8 hit latency", 32'(c_cyc), 32'(i + 2));
    end
    // R7 set misses
    run(0, 1'b1, hz(mhz[5]) + 1);
    chk(c_er && c_ec && c_rate == 0 && c_iv == 0 && c_fv == 0 && c_ov == 0,
        "R7 miss", {c_er, c_ec}, 32'd3);
    run(0, 1'b1, 32'd0);
    chk(c_er && c_ec && c_rate == 0, "R7 miss zero", {c_er, c_ec}, 32'd3);

    // R9 hold after done
    run(0, 1'b0, 32'd700000000);
    repeat (5) @(negedge clk);
    chk(!dn[0] && !bz[0], "R9 done pulse", {dn[0], bz[0]}, 0);
    chk(rt[0] == 32'd700000000 && fv[0] == 7'd20 && !er[0], "R9 hold", rt[0], 32'd700000000);

    // R10 start during walk is ignored
    mode = 1'b0; req = 32'd450000000; st[0] = 1'b1;
    @(negedge clk);
    st[0] = 1'b0;
    chk(bz[0], "R11 busy", 32'(bz[0]), 1);
    mode = 1'b1; req = 32'd100000000; st[0] = 1'b1;
    @(negedge clk);
    st[0] = 1'b0;
    c_cyc = 0;
    while (!dn[0] && c_cyc < 100) begin @(negedge clk); c_cyc++; end
    chk(rt[0] == 32'd400000000 && !er[0], "R10 ignored start", rt[0], 32'd400000000);
    chk(!bz[0], "R11 idle at done", 32'(bz[0]), 0);
    @(negedge clk);
    chk(!bz[0] && !dn[0], "R10 no second walk", {bz[0], dn[0]}, 0);

    // R12/R4 video table, full depth without terminator
    run(1, 1'b0, 32'd280000000);
    chk(!c_er && c_rate == 32'd297000000 && c_iv == 0 && c_fv == 21 && c_ov == 2 && c_bd == 0,
        "R12 video 297", c_rate, 32'd297000000);
    run(1, 1'b0, 32'd1000000000);
    chk(!c_er && c_rate == 32'd594000000 && c_fv == 21 && c_ov == 1, "R4 last entry", c_rate, 32'd594000000);
    run(1, 1'b1, 32'd540000000);
    chk(!c_er && c_rate == 32'd540000000 && c_fv == 19 && c_ov == 1, "R6 video set", c_rate, 32'd540000000);
    chk(c_cyc == 3, "R8 video latency", 32'(c_cyc), 3);
    run(1, 1'b1, 32'd600000000);
    chk(c_er && c_ec, "R7 video miss", {c_er, c_ec}, 3);
    chk(c_cyc == 4, "R4 walk stops at depth", 32'(c_cyc), 4);

    // R5 empty table
    run(2, 1'b0, 32'd500000000);
    chk(c_er && !c_ec && c_rate == 0, "R5 empty round", {c_er, c_ec}, 2);
    run(2, 1'b1, 32'd500000000);
    chk(c_er && c_ec, "R7 empty set", {c_er, c_ec}, 3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule